// File: doc/BRIEF.md
# Recursive Even-Odd Load Address Generator

This block produces the cache write address for each digit of a long operand as it streams in, so that the digits land directly in the order a recursive even/odd transform needs. The stream holds `LEAF << LEVELS` digits (98304 with the default 12 and 13), least significant first, at most one per cycle. Conceptually the index set is split into its even-indexed and odd-indexed halves, the even half placed first. That split is then repeated inside every half, `LEVELS` times, leaving `2^LEVELS` blocks of `LEAF` digits each.

The length is not a power of two, so this is not a plain bit reversal. For input index `i`, the low `LEVELS` bits of `i` are reversed to give the block number. The quotient `i / 2^LEVELS` gives the slot inside the block. The address is `block * LEAF + slot`. The index is kept as a split counter (a low binary field plus a slot field that wraps at `LEAF`), so no divider is needed.

A `start_i` pulse arms the generator. Every `digit_valid_i` cycle while armed then consumes one index. The matching address appears on a registered output with `wr_valid_o`. `done_o` pulses alongside the address of the final digit.

Top module: `eo_load_agen`

## Requirements
- R1: After reset with `rst_n` low, `busy_o`, `wr_valid_o` and `done_o` are all 0.
- R2: The cycle after `start_i` is sampled high, `busy_o` is 1 and `wr_valid_o` is 0; the next accepted digit has index 0. A `digit_valid_i` in the same cycle as `start_i` is not accepted.
- R3: A digit is accepted on a clock edge where `busy_o` is 1, `digit_valid_i` is 1 and `start_i` is 0. In the cycle after that edge, `wr_valid_o` is 1 and `wr_addr_o` equals `bitrev_LEVELS(i mod 2^LEVELS) * LEAF + (i div 2^LEVELS)` for that digit's index `i`.
- R4: Cycles with `digit_valid_i` low do not advance the index and give `wr_valid_o` 0 in the following cycle.
- R5: `done_o` is 1 for exactly one cycle: the cycle after the digit with index `LEAF*2^LEVELS - 1` is accepted. In that cycle `busy_o` is 0.
- R6: Over one full stream, the addresses written are all distinct and together cover 0 to `LEAF*2^LEVELS - 1`, each below that count. They equal the positions given by the repeated even-first split.
- R7: A `start_i` while busy restarts the stream: the next accepted digit again has index 0.
- R8: While `busy_o` is 0, `digit_valid_i` is ignored: `wr_valid_o` stays 0 and the index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Arms the generator and clears the index |
| digit_valid_i | input | 1 | One digit offered this cycle |
| wr_valid_o | output | 1 | `wr_addr_o` holds a fresh address |
| wr_addr_o | output | ADDR_W | Cache location of the accepted digit |
| busy_o | output | 1 | Generator armed and waiting for digits |
| done_o | output | 1 | One-cycle pulse with the last address |

## Verification
Every result here is due one clock edge after its cause. The address, `wr_valid_o` and `done_o` for a digit appear in the cycle after the edge that accepts it. `busy_o` changes in the cycle after `start_i` or after the final acceptance. The bench drives its inputs on the falling edge and compares the outputs at the next falling edge against a model that it advances by the same one-edge step. The expected addresses come from an explicit repeated even/odd partition of an index list, not from the bit-reversal formula. A bitmap over all addresses confirms that a full stream is a permutation.

// File: rtl/eo_load_pkg.sv
// Package: shared defaults for the even/odd load address generator.
// Assumes LEAF >= 2 and LEVELS >= 1.
package eo_load_pkg;
    localparam int unsigned DEF_LEAF   = 12;
    localparam int unsigned DEF_LEVELS = 13;
endpackage

// File: rtl/eo_index_counter.sv
// Split index counter: lo_o counts the low LEVELS bits of the digit index,
// hi_o counts completed passes of lo_o and wraps at LEAF.
// Assumes clear_i has priority over step_i.
module eo_index_counter #(
    parameter int unsigned LEAF   = eo_load_pkg::DEF_LEAF,
    parameter int unsigned LEVELS = eo_load_pkg::DEF_LEVELS,
    localparam int unsigned POS_W = $clog2(LEAF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [LEVELS-1:0] lo_o,
    output logic [POS_W-1:0]  hi_o,
    output logic              last_o
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LEAF - 1);

    logic lo_wrap;
    assign lo_wrap = &lo_o;
    assign last_o  = lo_wrap && (hi_o == POS_LAST);

    // advance the split index by one digit, or clear it
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            lo_o <= '0;
            hi_o <= '0;
        end else if (step_i) begin
            lo_o <= lo_o + 1'b1;
            if (lo_wrap) begin
                hi_o <= last_o ? '0 : hi_o + 1'b1;
            end
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_o <= POS_LAST); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> ($stable(lo_o) && $stable(hi_o))); // R4
endmodule

// File: rtl/eo_bit_mirror.sv
// Reverses the bit order of a WIDTH-bit value; purely combinational.
module eo_bit_mirror #(
    parameter int unsigned WIDTH = eo_load_pkg::DEF_LEVELS
) (
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_mirror
        assign out_o[g] = in_i[WIDTH-1-g];
    end
endmodule

// File: rtl/eo_addr_compose.sv
// Registers block * LEAF + slot as the write address when load_i is high.
// Assumes slot_i < LEAF.
module eo_addr_compose #(
    parameter int unsigned LEAF   = eo_load_pkg::DEF_LEAF,
    parameter int unsigned LEVELS = eo_load_pkg::DEF_LEVELS,
    localparam int unsigned POS_W  = $clog2(LEAF),
    localparam int unsigned TOTAL  = LEAF << LEVELS,
    localparam int unsigned ADDR_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LEVELS-1:0] block_i,
    input  logic [POS_W-1:0]  slot_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d;
    assign addr_d = ADDR_W'(block_i) * ADDR_W'(LEAF) + ADDR_W'(slot_i);

    // capture the composed address for an accepted digit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= addr_d;
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o < ADDR_W'(TOTAL))); // R6
endmodule

// File: rtl/eo_load_agen.sv
// Top: maps a least-significant-first digit stream to transform-order
// cache addresses (repeated even/odd split down to blocks of LEAF digits).
// Assumes one digit at most per cycle; start_i restarts at any time.
module eo_load_agen #(
    parameter int unsigned LEAF   = eo_load_pkg::DEF_LEAF,
    parameter int unsigned LEVELS = eo_load_pkg::DEF_LEVELS,
    localparam int unsigned POS_W  = $clog2(LEAF),
    localparam int unsigned TOTAL  = LEAF << LEVELS,
    localparam int unsigned ADDR_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              digit_valid_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              accept;
    logic              last;
    logic [LEVELS-1:0] lo;
    logic [LEVELS-1:0] block;
    logic [POS_W-1:0]  slot;

    assign accept = busy_o && digit_valid_i && !start_i;

    eo_index_counter #(.LEAF(LEAF), .LEVELS(LEVELS)) u_count (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .step_i(accept),
        .lo_o(lo), .hi_o(slot), .last_o(last)
    );

    eo_bit_mirror #(.WIDTH(LEVELS)) u_mirror (
        .in_i(lo), .out_o(block)
    );

    eo_addr_compose #(.LEAF(LEAF), .LEVELS(LEVELS)) u_compose (
        .clk(clk), .rst_n(rst_n), .load_i(accept),
        .block_i(block), .slot_i(slot), .addr_o(wr_addr_o)
    );

    // armed state: set by start, cleared by the final accepted digit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
        end else if (start_i) begin
            busy_o <= 1'b1;
        end else if (accept && last) begin
            busy_o <= 1'b0;
        end
    end

    // output strobes aligned with the registered address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            wr_valid_o <= accept;
            done_o     <= accept && last;
        end
    end

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !wr_valid_o && !done_o)); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && wr_valid_o)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !wr_valid_o); // R8
endmodule

// File: tb/eo_load_agen_test.sv
module eo_load_agen_test;
    localparam int LEAF   = 12;
    localparam int LEVELS = 4;
    localparam int TOTAL  = LEAF << LEVELS;
    localparam int ADDR_W = $clog2(TOTAL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dvalid = 1'b0;
    logic wr_valid, busy, done;
    logic [ADDR_W-1:0] wr_addr;

    always #5 clk = ~clk;

    eo_load_agen #(.LEAF(LEAF), .LEVELS(LEVELS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .digit_valid_i(dvalid),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .busy_o(busy), .done_o(done)
    );

    int checks = 0;
    int fails  = 0;
    int exp_pos [TOTAL];
    bit seen    [TOTAL];

    // bench model state
    bit m_busy = 0;
    int m_idx = 0;
    bit n_wv = 0, n_done = 0;
    int n_addr = 0;
    string tag = "R3";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected positions from an explicit repeated even-first partition
    task automatic build_model();
        int lst [TOTAL];
        int tmp [TOTAL];
        for (int k = 0; k < TOTAL; k++) lst[k] = k;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            int blk = TOTAL >> lvl;
            int half = blk / 2;
            for (int base = 0; base < TOTAL; base += blk) begin
                for (int j = 0; j < half; j++) begin
                    tmp[base + j]        = lst[base + 2*j];
                    tmp[base + half + j] = lst[base + 2*j + 1];
                end
            end
            for (int k = 0; k < TOTAL; k++) lst[k] = tmp[k];
        end
        for (int p = 0; p < TOTAL; p++) exp_pos[lst[p]] = p;
    endtask

    // one cycle: compare outputs from the last edge, then drive new inputs
    task automatic step(input bit v, input bit s);
        @(negedge clk);
        chk({tag, " wr_valid"}, int'(wr_valid), int'(n_wv));
        if (n_wv) chk({tag, " wr_addr"}, int'(wr_addr), n_addr);
        chk("R5 done", int'(done), int'(n_done));
        chk("R2 busy", int'(busy), int'(m_busy));
        start = s;
        dvalid = v;
        n_wv = 0;
        n_done = 0;
        if (s) begin
            m_busy = 1;
            m_idx = 0;
        end else if (v && m_busy) begin
            n_wv = 1;
            n_addr = exp_pos[m_idx];
            seen[n_addr] = 1;
            n_done = (m_idx == TOTAL - 1);
            if (n_done) m_busy = 0;
            m_idx++;
        end
    endtask

    task automatic clear_seen();
        for (int k = 0; k < TOTAL; k++) seen[k] = 0;
    endtask

    task automatic check_perm();
        int cnt = 0;
        for (int k = 0; k < TOTAL; k++) cnt += int'(seen[k]);
        chk("R6 distinct addresses", cnt, TOTAL);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        build_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 wr_valid", int'(wr_valid), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;

        // R8: valid while idle is ignored
        tag = "R8";
        for (int k = 0; k < 5; k++) step(1, 0);

        // R2/R3/R6: continuous full stream, valid in start cycle ignored
        tag = "R3";
        clear_seen();
        step(1, 1);
        for (int k = 0; k < TOTAL; k++) step(1, 0);
        tag = "R5";
        step(1, 0);
        step(1, 0);
        check_perm();

        // R4: stream with gaps
        tag = "R4";
        clear_seen();
        step(0, 1);
        for (int k = 0; k < 3 * TOTAL; k++) step(((k % 3) != 1) && ((k % 7) != 4), 0);
        step(0, 0);
        step(0, 0);

        // R7: restart mid-stream, then a full stream must still complete
        tag = "R7";
        step(0, 1);
        for (int k = 0; k < 37; k++) step(1, 0);
        clear_seen();
        step(1, 1);
        for (int k = 0; k < TOTAL; k++) step(1, 0);
        step(0, 0);
        check_perm();

        // R8: after done, valid is ignored again
        tag = "R8";
        for (int k = 0; k < 4; k++) step(1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule